// File: doc/BRIEF.md
# Dual-Channel Card Interrupt Controller

This block is the byte-wide slave register set of a two-channel disk interface expansion card. It owns one interrupt enable and one status latch per channel and drives a single combined pending line to the host. Software turns a channel's interrupt on with any write to that channel's control location and turns it off with any read of the same location. The data written does not matter. A channel with no drive attached can therefore be left disabled, and its floating request line then raises nothing.

The block also returns a strapped board type code and holds a port-select byte. The port-select byte chooses which channel receives the shared DMA strobes and opens the channel register window. The type code is spread out one bit per word: software reads bit 0 at four addresses spaced four bytes apart and assembles the code, lowest bit first. A code of 15 identifies the older single-channel board. Writing zero to the port-select byte closes the channel window again, which returns the card to its identification state.

Each drive request passes through a synchronizer. A channel's status latch sets only on a rising edge of that synchronized request while the channel is enabled. The latch clears when the request drops or when the channel is disabled.

Top module: `card_irq_ctl`

## Requirements
- R1: After reset all channel enables and status latches are 0, `irq_pending` is 0, the port-select byte reads 0x00 (so `dma_chan_sel` and `region_en` are 0) and `bus_rdata` is 0x00.
- R2: While `region_en` is 1, a write of any data to a channel's control address (channel 0 at 0x2200, channel 1 at 0x3200) enables that channel. A read of the same address disables the channel, clears its status latch and returns 0x00. If both strobes arrive together, the read wins.
- R3: Bit 0 of a channel's status address (channel 0 at 0x2290, channel 1 at 0x3290) reads that channel's latch, and bits 7:1 read 0. With the default two synchronizer stages, the latch sets on the third clock edge that samples the request high. It clears on the third edge that samples the request low.
- R4: The latch responds only to a rising edge of the request. If a request is already high when the channel is enabled, the channel stays idle until the request falls and rises again.
- R5: `irq_pending` is the OR of the channel status latches.
- R6: If a rising request edge falls in the same cycle as a disabling read, the latch stays clear. If it falls in the same cycle as an enabling write, the latch also stays clear, because the new enable only applies from the next cycle.
- R7: A read of address 0x2280 + 4·k returns `board_id[k]` in bit 0 and zeros above it, for k = 0..3. This holds whatever the state of `region_en`.
- R8: Address 0x0000 is the port-select byte. It is written whole and reads back whole. Bit 0 drives `dma_chan_sel` and bit 1 drives `region_en`. Writing 0x00 clears both outputs.
- R9: While `region_en` is 0, accesses to the control and status addresses change nothing and read 0x00.
- R10: Read data is registered and appears the cycle after the read strobe. In any cycle without a read it is 0x00. Reads of undecoded addresses return 0x00 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| drv_irq | input | 2 | Per-channel drive interrupt requests, asynchronous |
| board_id | input | 4 | Strapped board type code |
| irq_pending | output | 1 | Combined interrupt to the host |
| dma_chan_sel | output | 1 | Channel that receives the shared DMA strobes |
| region_en | output | 1 | Channel register window open |

## Verification
The hazardous overlap is a synchronized request edge arriving in the same cycle as a control access on that channel. The bench raises the request, then places a disabling read, and separately an enabling write, exactly on the cycle in which the edge is seen after two synchronizer stages. It then expects the latch to stay clear and `irq_pending` to stay low. A later fresh edge on the still-enabled channel confirms that the write did take effect.

// File: rtl/cic_pkg.sv
package cic_pkg;

   localparam int MAX_CH     = 2;
   localparam int SEL_BIT    = 0;
   localparam int REGION_BIT = 1;

   typedef struct packed {
      logic              psel;
      logic [MAX_CH-1:0] ctrl;
      logic [MAX_CH-1:0] stat;
   } cic_hit_t;

endpackage

// File: rtl/cic_decode.sv
module cic_decode
   import cic_pkg::*;
#(
   parameter int ADDR_W       = 14,
   parameter int NUM_CH       = 2,
   parameter int CH_CTRL_BASE = 'h2200,
   parameter int CH_STRIDE    = 'h1000,
   parameter int STAT_OFS     = 'h0090,
   parameter int PSEL_ADDR    = 'h0000,
   parameter int ID_BASE      = 'h2280,
   parameter int ID_STEP      = 4,
   parameter int ID_BITS      = 4
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               region_en,
   output cic_hit_t           hit,
   output logic [ID_BITS-1:0] id_hit
);

   always_comb begin
      hit      = '0;
      hit.psel = (addr == ADDR_W'(PSEL_ADDR));
      for (int i = 0; i < NUM_CH; i++) begin
         hit.ctrl[i] = region_en && (addr == ADDR_W'(CH_CTRL_BASE + i * CH_STRIDE));
         hit.stat[i] = region_en && (addr == ADDR_W'(CH_CTRL_BASE + i * CH_STRIDE + STAT_OFS));
      end
   end

   for (genvar k = 0; k < ID_BITS; k++) begin : g_id
      assign id_hit[k] = (addr == ADDR_W'(ID_BASE + k * ID_STEP));
   end

endmodule

// File: rtl/cic_chan.sv
module cic_chan #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   input  logic en_set,
   input  logic en_clr,
   output logic en_q,
   output logic stat_q,
   output logic req_sync
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   req_d;
   logic                   req_rise;

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= req_in;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_in};
      end
   end

   assign req_sync = sync_q[SYNC_STAGES-1];
   assign req_rise = req_sync & ~req_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= 1'b0;
      else        req_d <= req_sync;
   end

   // read strobe has priority over write strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (en_clr) en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;
   end

   // latch uses the enable as it stood before this edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    stat_q <= 1'b0;
      else if (en_clr || !req_sync)  stat_q <= 1'b0;
      else if (en_q && req_rise)     stat_q <= 1'b1;
   end

endmodule

// File: rtl/cic_portsel.sv
module cic_portsel
   import cic_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] reg_q,
   output logic              chan_sel,
   output logic              window_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  reg_q <= '0;
      else if (wr) reg_q <= wdata;
   end

   assign chan_sel  = reg_q[SEL_BIT];
   assign window_en = reg_q[REGION_BIT];

endmodule

// File: rtl/card_irq_ctl.sv
module card_irq_ctl
   import cic_pkg::*;
#(
   parameter int ADDR_W       = 14,
   parameter int DATA_W       = 8,
   parameter int NUM_CH       = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int CH_CTRL_BASE = 'h2200,
   parameter int CH_STRIDE    = 'h1000,
   parameter int STAT_OFS     = 'h0090,
   parameter int PSEL_ADDR    = 'h0000,
   parameter int ID_BASE      = 'h2280,
   parameter int ID_STEP      = 4,
   parameter int ID_BITS      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_CH-1:0]  drv_irq,
   input  logic [ID_BITS-1:0] board_id,
   output logic               irq_pending,
   output logic               dma_chan_sel,
   output logic               region_en
);

   localparam int TOP_ADDR = CH_CTRL_BASE + (NUM_CH - 1) * CH_STRIDE + STAT_OFS;
   localparam int ID_TOP   = ID_BASE + (ID_BITS - 1) * ID_STEP;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("card_irq_ctl: NUM_CH must be 1..%0d", MAX_CH);
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("card_irq_ctl: SYNC_STAGES must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("card_irq_ctl: DATA_W must hold select and window bits");
   end
   if (ID_BITS < 1 || ID_BITS > DATA_W) begin : g_bad_id
      $error("card_irq_ctl: ID_BITS out of range");
   end
   if (TOP_ADDR >= (1 << ADDR_W) || ID_TOP >= (1 << ADDR_W)) begin : g_bad_addr
      $error("card_irq_ctl: register map exceeds ADDR_W");
   end

   cic_hit_t            hit;
   logic [ID_BITS-1:0]  id_hit;
   logic [DATA_W-1:0]   psel_q;
   logic [NUM_CH-1:0]   ch_en;
   logic [NUM_CH-1:0]   ch_stat;
   logic [NUM_CH-1:0]   ch_sync;
   logic [DATA_W-1:0]   rd_mux;
   logic [DATA_W-1:0]   rdata_q;

   cic_decode #(
      .ADDR_W       (ADDR_W),
      .NUM_CH       (NUM_CH),
      .CH_CTRL_BASE (CH_CTRL_BASE),
      .CH_STRIDE    (CH_STRIDE),
      .STAT_OFS     (STAT_OFS),
      .PSEL_ADDR    (PSEL_ADDR),
      .ID_BASE      (ID_BASE),
      .ID_STEP      (ID_STEP),
      .ID_BITS      (ID_BITS)
   ) u_decode (
      .addr      (bus_addr),
      .region_en (region_en),
      .hit       (hit),
      .id_hit    (id_hit)
   );

   cic_portsel #(
      .DATA_W (DATA_W)
   ) u_portsel (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (bus_wr & hit.psel),
      .wdata     (bus_wdata),
      .reg_q     (psel_q),
      .chan_sel  (dma_chan_sel),
      .window_en (region_en)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      cic_chan #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_in   (drv_irq[i]),
         .en_set   (bus_wr & hit.ctrl[i]),
         .en_clr   (bus_rd & hit.ctrl[i]),
         .en_q     (ch_en[i]),
         .stat_q   (ch_stat[i]),
         .req_sync (ch_sync[i])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (hit.psel) rd_mux = psel_q;
      for (int i = 0; i < NUM_CH; i++) begin
         if (hit.stat[i]) rd_mux[0] = ch_stat[i];
      end
      if (|(id_hit & board_id)) rd_mux[0] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
      else             rdata_q <= '0;
   end

   assign bus_rdata   = rdata_q;
   assign irq_pending = |ch_stat;

endmodule

// File: rtl/card_irq_ctl_chk.sv
module card_irq_ctl_chk #(
   parameter int ADDR_W       = 14,
   parameter int DATA_W       = 8,
   parameter int NUM_CH       = 2,
   parameter int CH_CTRL_BASE = 'h2200,
   parameter int CH_STRIDE    = 'h1000,
   parameter int PSEL_ADDR    = 'h0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_pending,
   input logic              dma_chan_sel,
   input logic              region_en,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] ch_stat,
   input logic [NUM_CH-1:0] ch_sync
);

   a_r5_pending_is_or: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending == (|ch_stat));

   a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0);

   a_r8_zero_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(PSEL_ADDR) && bus_wdata == '0
      |=> !region_en && !dma_chan_sel);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CH_CTRL_BASE + i * CH_STRIDE);

      a_r2_write_enables: assert property (@(posedge clk) disable iff (!rst_n)
         bus_wr && !bus_rd && region_en && bus_addr == CTRL_A |=> ch_en[i]);

      a_r2_read_disables: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rd && region_en && bus_addr == CTRL_A |=> !ch_en[i] && !ch_stat[i]);

      a_r3_low_request_clears: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_sync[i] |=> !ch_stat[i]);

      a_r4_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[i] |=> !$rose(ch_stat[i]));

      a_r9_closed_window_inert: assert property (@(posedge clk) disable iff (!rst_n)
         !region_en && (bus_wr || bus_rd) && bus_addr == CTRL_A |=> $stable(ch_en[i]));
   end

endmodule

bind card_irq_ctl card_irq_ctl_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .NUM_CH       (NUM_CH),
   .CH_CTRL_BASE (CH_CTRL_BASE),
   .CH_STRIDE    (CH_STRIDE),
   .PSEL_ADDR    (PSEL_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .irq_pending  (irq_pending),
   .dma_chan_sel (dma_chan_sel),
   .region_en    (region_en),
   .ch_en        (ch_en),
   .ch_stat      (ch_stat),
   .ch_sync      (ch_sync)
);

// File: tb/card_irq_ctl_tb.sv
`timescale 1ns/1ps
module card_irq_ctl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [1:0]  drv_irq = '0;
   logic [3:0]  board_id = 4'b1010;
   logic        irq_pending;
   logic        dma_chan_sel;
   logic        region_en;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   typedef struct {
      string       req;
      logic [7:0]  exp;
      logic [13:0] addr;
   } rd_item_t;

   rd_item_t exp_q[$];
   logic     rd_seen = 1'b0;

   always #10 clk = ~clk;

   card_irq_ctl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .drv_irq      (drv_irq),
      .board_id     (board_id),
      .irq_pending  (irq_pending),
      .dma_chan_sel (dma_chan_sel),
      .region_en    (region_en)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard one cycle after each read strobe
   always @(posedge clk) rd_seen <= bus_rd;

   always @(negedge clk) begin
      rd_item_t it;
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            total++;
            bad++;
            $display("FAIL R10 unexpected read data actual=%0h expected=none", bus_rdata);
         end else begin
            it = exp_q.pop_front();
            check(it.req, $sformatf("read %h", it.addr), bus_rdata, it.exp);
         end
      end
   end

   task automatic bus_write(input logic [13:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [13:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      exp_q.push_back('{req, exp, a});
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_pend(input string req, input logic exp);
      check(req, "irq_pending", {7'b0, irq_pending}, {7'b0, exp});
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R1 reset state
      chk_pend("R1", 1'b0);
      check("R1", "dma_chan_sel", {7'b0, dma_chan_sel}, 8'h00);
      check("R1", "region_en", {7'b0, region_en}, 8'h00);
      check("R1", "rdata idle", bus_rdata, 8'h00);
      bus_read(14'h0000, 8'h00, "R1");

      // R9 closed window: enable write ignored
      bus_write(14'h2200, 8'hFF);
      drv_irq[0] = 1'b1;
      wait_cyc(5);
      chk_pend("R9", 1'b0);
      bus_read(14'h2290, 8'h00, "R9");
      drv_irq[0] = 1'b0;
      wait_cyc(4);

      // R8 port select
      bus_write(14'h0000, 8'h02);
      check("R8", "region_en", {7'b0, region_en}, 8'h01);
      check("R8", "dma_chan_sel", {7'b0, dma_chan_sel}, 8'h00);
      bus_write(14'h0000, 8'h03);
      check("R8", "dma_chan_sel", {7'b0, dma_chan_sel}, 8'h01);
      bus_read(14'h0000, 8'h03, "R8");
      bus_write(14'h0000, 8'h02);
      check("R8", "dma_chan_sel back", {7'b0, dma_chan_sel}, 8'h00);

      // R9 follow-up: channel 0 still disabled after the ignored write
      drv_irq[0] = 1'b1;
      wait_cyc(5);
      chk_pend("R9", 1'b0);
      drv_irq[0] = 1'b0;
      wait_cyc(4);

      // R2 enable with zero data, R3 latency
      bus_write(14'h2200, 8'h00);
      drv_irq[0] = 1'b1;
      wait_cyc(1); chk_pend("R3", 1'b0);
      wait_cyc(1); chk_pend("R3", 1'b0);
      wait_cyc(1); chk_pend("R3", 1'b1);
      bus_read(14'h2290, 8'h01, "R3");
      bus_read(14'h3290, 8'h00, "R3");
      chk_pend("R5", 1'b1);
      drv_irq[0] = 1'b0;
      wait_cyc(1); chk_pend("R3", 1'b1);
      wait_cyc(1); chk_pend("R3", 1'b1);
      wait_cyc(1); chk_pend("R3", 1'b0);
      bus_read(14'h2290, 8'h00, "R3");

      // R2 disable by read
      bus_read(14'h2200, 8'h00, "R2");
      drv_irq[0] = 1'b1;
      wait_cyc(5);
      chk_pend("R2", 1'b0);
      bus_read(14'h2290, 8'h00, "R2");
      drv_irq[0] = 1'b0;
      wait_cyc(4);

      // R4 request already high when enabled
      drv_irq[1] = 1'b1;
      wait_cyc(4);
      bus_write(14'h3200, 8'h77);
      wait_cyc(5);
      chk_pend("R4", 1'b0);
      bus_read(14'h3290, 8'h00, "R4");
      drv_irq[1] = 1'b0;
      wait_cyc(4);
      drv_irq[1] = 1'b1;
      wait_cyc(4);
      chk_pend("R4", 1'b1);
      bus_read(14'h3290, 8'h01, "R4");

      // R5 OR of two channels, R2 read clears latch
      bus_write(14'h2200, 8'h01);
      drv_irq[0] = 1'b1;
      wait_cyc(4);
      bus_read(14'h2290, 8'h01, "R5");
      bus_read(14'h3200, 8'h00, "R2");
      chk_pend("R5", 1'b1);
      bus_read(14'h3290, 8'h00, "R2");
      bus_read(14'h2200, 8'h00, "R2");
      chk_pend("R5", 1'b0);
      drv_irq = 2'b00;
      wait_cyc(4);

      // R6 edge meets disabling read
      bus_write(14'h2200, 8'hA5);
      drv_irq[0] = 1'b1;
      @(negedge clk);
      bus_read(14'h2200, 8'h00, "R6");
      wait_cyc(3);
      chk_pend("R6", 1'b0);
      bus_read(14'h2290, 8'h00, "R6");
      drv_irq[0] = 1'b0;
      wait_cyc(4);

      // R6 edge meets enabling write
      drv_irq[0] = 1'b1;
      @(negedge clk);
      bus_write(14'h2200, 8'h3C);
      wait_cyc(3);
      chk_pend("R6", 1'b0);
      drv_irq[0] = 1'b0;
      wait_cyc(4);
      drv_irq[0] = 1'b1;
      wait_cyc(4);
      chk_pend("R6", 1'b1);
      bus_read(14'h2200, 8'h00, "R2");
      chk_pend("R2", 1'b0);
      drv_irq[0] = 1'b0;
      wait_cyc(4);

      // R7 board type, two patterns
      bus_read(14'h2280, 8'h00, "R7");
      bus_read(14'h2284, 8'h01, "R7");
      bus_read(14'h2288, 8'h00, "R7");
      bus_read(14'h228C, 8'h01, "R7");
      board_id = 4'b0101;
      bus_read(14'h2280, 8'h01, "R7");
      bus_read(14'h2284, 8'h00, "R7");
      bus_read(14'h2288, 8'h01, "R7");
      bus_read(14'h228C, 8'h00, "R7");
      bus_read(14'h2281, 8'h00, "R10");

      // R10 undecoded accesses have no effect
      bus_write(14'h2200, 8'h00);
      bus_read(14'h1234, 8'h00, "R10");
      bus_read(14'h2204, 8'h00, "R10");
      bus_write(14'h2290, 8'hFF);
      drv_irq[0] = 1'b1;
      wait_cyc(4);
      chk_pend("R10", 1'b1);
      bus_read(14'h2290, 8'h01, "R10");

      // R8 zero write closes window, R9 gated reads
      bus_write(14'h0000, 8'h00);
      check("R8", "region_en", {7'b0, region_en}, 8'h00);
      check("R8", "dma_chan_sel", {7'b0, dma_chan_sel}, 8'h00);
      bus_read(14'h0000, 8'h00, "R8");
      bus_read(14'h2290, 8'h00, "R9");
      bus_read(14'h2200, 8'h00, "R9");
      chk_pend("R9", 1'b1);
      bus_read(14'h2288, 8'h01, "R7");
      drv_irq[0] = 1'b0;
      wait_cyc(4);
      chk_pend("R3", 1'b0);

      wait_cyc(3);
      if (exp_q.size() != 0) begin
         total++;
         bad++;
         $display("FAIL R10 reads unanswered actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule